// File: doc/BRIEF.md
# Pixel Output Formatter with Blanking

This block is the digital output stage of an imaging front end. Each pixel clock it accepts one pixel code and the state of two timing windows: a blanking window and a black-clamp window. The code travels through a fixed-depth register pipeline. The blanking decision for that pixel travels with it. At the end of the pipeline the code can be replaced by zero or by the programmed clamp level. It can then be re-coded as Gray code. Finally it is either captured in an output register or passed through without that register.

The data clock is an input sampled in the pixel clock domain. In latched mode the output register loads only on pixel clock edges where the data clock is at its active level. In transparent mode the output follows the last pipeline stage directly. The polarity of the data clock and of the blanking input can each be programmed. A three-state control is modelled as an output-enable signal that sits beside the data bus.

Top module: `pixel_out_fmt`

## Requirements
- R1: Reset is synchronous on the rising clock edge with `rst_n` low. After reset, `data_out` reads 0 in both output modes until new pixels reach the output.
- R2: Latency. With `cfg_transparent`=0 and the data clock always active, a code sampled on one rising edge appears on `data_out` after the LAT-th rising edge, counting the sampling edge as the first (LAT defaults to 9). With `cfg_transparent`=1 it appears one edge earlier, after the (LAT-1)-th edge.
- R3: When the blanking window is active for a pixel, the clamp window is inactive for it, and `cfg_blank_lvl`=0, the output for that pixel is all zeros. This holds in both binary and Gray coding.
- R4: When the blanking window is active for a pixel, the clamp window is inactive for it, and `cfg_blank_lvl`=1, the output is `clamp_level` zero-extended to the pixel width, before coding is applied.
- R5: A pixel sampled while `clp_win`=1 is never blanked, whatever the state of the blanking input.
- R6: With `cfg_gray`=0 the output is straight binary. With `cfg_gray`=1 the output is v ^ (v >> 1), where v is the value after blanking.
- R7: With `cfg_transparent`=0 the output register loads only on edges where the data clock is active. On other edges it holds its value.
- R8: With `cfg_transparent`=1 the output follows the last pipeline stage whatever the data clock does.
- R9: `data_oe` is 0 when `cfg_tristate`=1 and 1 when `cfg_tristate`=0.
- R10: Polarity bits `cfg_dclk_pol` and `cfg_pblk_pol`: 1 makes the matching input active high, and 0 makes it active low.
- R11: The blanking decision is taken when the pixel is sampled and is applied to that same pixel at the output. Pixels on either side of it are not blanked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_code | input | PIX_W | Pixel code sampled each clock |
| dclk | input | 1 | Data clock level, sampled by `clk` |
| pblk | input | 1 | Blanking window input, polarity set by `cfg_pblk_pol` |
| clp_win | input | 1 | Black-clamp window, active high |
| clamp_level | input | CLAMP_W | Level substituted when blanking to clamp level |
| cfg_blank_lvl | input | 1 | 0 = blank to zero, 1 = blank to clamp level |
| cfg_gray | input | 1 | 0 = binary output, 1 = Gray output |
| cfg_transparent | input | 1 | 0 = output register, 1 = transparent |
| cfg_tristate | input | 1 | 1 = outputs disabled |
| cfg_dclk_pol | input | 1 | Data clock polarity, 1 = active high |
| cfg_pblk_pol | input | 1 | Blanking polarity, 1 = active high |
| data_out | output | PIX_W | Formatted pixel code |
| data_oe | output | 1 | Output enable for the data bus |

## Verification
A table of steady-state cases holds one code until it fills the pipeline. These cases separate the blanking target (zero or clamp level), the coding (binary or Gray), clamp-over-blank priority and active-low blanking. Together they show that blanking is applied before coding. A single marker code among zeros measures the latency in each output mode. A run of consecutive codes with one blanked pixel shows that the blanking flag stays aligned with its own pixel. A held-then-released data clock shows that the output register holds while the data clock is inactive and that transparent mode ignores it. It also checks the data clock polarity inversion.

// File: rtl/pof_pkg.sv
// Package: defaults and polarity helper shared by the output formatter.
// Assumes: all users take their widths from these defaults unless overridden.
package pof_pkg;
    localparam int DEF_PIX_W   = 12;
    localparam int DEF_CLAMP_W = 8;
    localparam int DEF_LAT     = 9;

    typedef enum logic {
        POL_LOW  = 1'b0,
        POL_HIGH = 1'b1
    } pol_e;

    // Return 1 when the raw level equals the programmed active level.
    function automatic logic is_active(input logic raw, input pol_e pol);
        return (pol == POL_HIGH) ? raw : ~raw;
    endfunction
endpackage

// File: rtl/pof_qualify.sv
// Module: input qualification. It applies the programmed polarities to the
// blanking input and the data clock, and lets the clamp window override
// blanking. Purely combinational; clk/rst_n serve the assertion only.
module pof_qualify
    import pof_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pblk_raw,
    input  logic pblk_pol,
    input  logic clp_win,
    input  logic dclk_raw,
    input  logic dclk_pol,
    output logic blank_o,
    output logic dclk_act_o
);
    logic pblk_act;

    // Resolve polarity and the clamp-over-blank priority.
    always_comb begin
        pblk_act   = is_active(pblk_raw, pol_e'(pblk_pol));
        dclk_act_o = is_active(dclk_raw, pol_e'(dclk_pol));
        blank_o    = pblk_act & ~clp_win;
    end

    // R5: a clamp window sample never yields a blank flag.
    assert_clamp_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clp_win |-> !blank_o);
endmodule

// File: rtl/pof_delay.sv
// Module: fixed-depth delay line that carries each pixel code together
// with its blank flag. Assumes DEPTH >= 1; reset clears every stage.
module pof_delay #(
    parameter int W     = 13,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            // First stage captures the input word.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= din;
            end
        end else begin : g_body
            // Later stages shift the word by one.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign dout = stage_q[DEPTH-1];
endmodule

// File: rtl/pof_encode.sv
// Module: output value selection. It substitutes zero or the clamp level
// for blanked pixels and then applies Gray coding when enabled.
// Assumes CLAMP_W <= PIX_W. Combinational; clk/rst_n serve assertions only.
module pof_encode #(
    parameter int PIX_W   = 12,
    parameter int CLAMP_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               blank,
    input  logic [PIX_W-1:0]   code_in,
    input  logic [CLAMP_W-1:0] clamp_level,
    input  logic               cfg_blank_lvl,
    input  logic               cfg_gray,
    output logic [PIX_W-1:0]   code_out
);
    logic [PIX_W-1:0] val;

    // Pick the post-blanking value, then code it.
    always_comb begin
        if (!blank)             val = code_in;
        else if (cfg_blank_lvl) val = PIX_W'(clamp_level);
        else                    val = '0;
        code_out = cfg_gray ? (val ^ (val >> 1)) : val;
    end

    // R3: blank to zero gives zero in either coding.
    assert_blank_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (blank && !cfg_blank_lvl) |-> (code_out == '0));

    // R6: consecutive unblanked codes differ in one Gray output bit.
    assert_gray_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_gray && $past(cfg_gray) && !blank && !$past(blank) &&
         code_in == PIX_W'($past(code_in) + 1'b1))
        |-> ($countones(code_out ^ $past(code_out)) == 1));
endmodule

// File: rtl/pixel_out_fmt.sv
// Module: pixel output formatter (top). It delays each code through a
// LAT-register path, applies blanking and coding, and then uses the output
// register (latched mode) or bypasses it (transparent mode).
// Assumes: LAT >= 2, all control inputs synchronous to clk.
module pixel_out_fmt
    import pof_pkg::*;
#(
    parameter int PIX_W   = DEF_PIX_W,
    parameter int CLAMP_W = DEF_CLAMP_W,
    parameter int LAT     = DEF_LAT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PIX_W-1:0]   pix_code,
    input  logic               dclk,
    input  logic               pblk,
    input  logic               clp_win,
    input  logic [CLAMP_W-1:0] clamp_level,
    input  logic               cfg_blank_lvl,
    input  logic               cfg_gray,
    input  logic               cfg_transparent,
    input  logic               cfg_tristate,
    input  logic               cfg_dclk_pol,
    input  logic               cfg_pblk_pol,
    output logic [PIX_W-1:0]   data_out,
    output logic               data_oe
);
    localparam int DEPTH = LAT - 1;
    localparam int SW    = PIX_W + 1;

    logic             blank_in;
    logic             dclk_act;
    logic [SW-1:0]    tail;
    logic [PIX_W-1:0] enc;
    logic [PIX_W-1:0] out_q;

    pof_qualify u_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .pblk_raw   (pblk),
        .pblk_pol   (cfg_pblk_pol),
        .clp_win    (clp_win),
        .dclk_raw   (dclk),
        .dclk_pol   (cfg_dclk_pol),
        .blank_o    (blank_in),
        .dclk_act_o (dclk_act)
    );

    pof_delay #(.W(SW), .DEPTH(DEPTH)) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({blank_in, pix_code}),
        .dout  (tail)
    );

    pof_encode #(.PIX_W(PIX_W), .CLAMP_W(CLAMP_W)) u_enc (
        .clk           (clk),
        .rst_n         (rst_n),
        .blank         (tail[SW-1]),
        .code_in       (tail[PIX_W-1:0]),
        .clamp_level   (clamp_level),
        .cfg_blank_lvl (cfg_blank_lvl),
        .cfg_gray      (cfg_gray),
        .code_out      (enc)
    );

    // Output register: loads only while the data clock is active.
    always_ff @(posedge clk) begin
        if (!rst_n)        out_q <= '0;
        else if (dclk_act) out_q <= enc;
    end

    // Output selection between register and transparent path.
    always_comb begin
        data_out = cfg_transparent ? enc : out_q;
        data_oe  = ~cfg_tristate;
    end

    // R7: an inactive data clock leaves the output register untouched.
    assert_dclk_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !dclk_act |=> $stable(out_q));
endmodule

// File: tb/test_pixel_out_fmt.sv
module test_pixel_out_fmt;
    localparam int LAT = 9;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] pix_code;
    logic        dclk, pblk, clp_win;
    logic [7:0]  clamp_level;
    logic        cfg_blank_lvl, cfg_gray, cfg_transparent, cfg_tristate;
    logic        cfg_dclk_pol, cfg_pblk_pol;
    logic [11:0] data_out;
    logic        data_oe;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pixel_out_fmt #(.LAT(LAT)) i_pixel_out_fmt (
        .clk(clk), .rst_n(rst_n), .pix_code(pix_code), .dclk(dclk),
        .pblk(pblk), .clp_win(clp_win), .clamp_level(clamp_level),
        .cfg_blank_lvl(cfg_blank_lvl), .cfg_gray(cfg_gray),
        .cfg_transparent(cfg_transparent), .cfg_tristate(cfg_tristate),
        .cfg_dclk_pol(cfg_dclk_pol), .cfg_pblk_pol(cfg_pblk_pol),
        .data_out(data_out), .data_oe(data_oe)
    );

    typedef struct packed {
        logic [11:0] code;
        logic        pblk;
        logic        ppol;
        logic        clp;
        logic        lvl;
        logic        gray;
        logic [7:0]  clamp;
        logic [11:0] exp;
    } vec_t;

    // Steady-state cases: input held until the pipeline is full.
    localparam vec_t VECS [0:12] = '{
        '{12'hA5C, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h80, 12'hA5C}, // R6 binary
        '{12'hA5C, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h80, 12'hF72}, // R6 gray
        '{12'h123, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h80, 12'h000}, // R3 bin
        '{12'h123, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h80, 12'h000}, // R3 gray
        '{12'h123, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h80, 12'h080}, // R4 bin
        '{12'h123, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h80, 12'h0C0}, // R4 gray
        '{12'h555, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'hFF, 12'h0FF}, // R4 max
        '{12'h555, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h3C, 12'h022}, // R4 gray
        '{12'h123, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h80, 12'h123}, // R5
        '{12'h7FF, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h80, 12'h400}, // R5 gray
        '{12'h123, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h80, 12'h000}, // R10 low
        '{12'h123, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h80, 12'h123}, // R10 low
        '{12'hFFF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h80, 12'h800}  // R6 top
    };

    task automatic chk(input string req, input logic [11:0] act,
                       input logic [11:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; pix_code = 12'h3C3; dclk = 1'b1; pblk = 1'b0;
        clp_win = 1'b0; clamp_level = 8'h80; cfg_blank_lvl = 1'b0;
        cfg_gray = 1'b0; cfg_transparent = 1'b0; cfg_tristate = 1'b0;
        cfg_dclk_pol = 1'b1; cfg_pblk_pol = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state in registered and transparent modes
        chk("R1 registered", data_out, 12'h000);
        cfg_transparent = 1'b1; #1;
        chk("R1 transparent", data_out, 12'h000);
        cfg_transparent = 1'b0;
        rst_n = 1'b1; pix_code = 12'h000;

        // R9: output enable follows the three-state bit
        chk("R9 enabled", {11'd0, data_oe}, 12'h001);
        cfg_tristate = 1'b1; #1;
        chk("R9 disabled", {11'd0, data_oe}, 12'h000);
        cfg_tristate = 1'b0;

        // Table walk (R3 R4 R5 R6 R10)
        foreach (VECS[i]) begin
            pix_code = VECS[i].code; pblk = VECS[i].pblk;
            cfg_pblk_pol = VECS[i].ppol; clp_win = VECS[i].clp;
            cfg_blank_lvl = VECS[i].lvl; cfg_gray = VECS[i].gray;
            clamp_level = VECS[i].clamp;
            repeat (LAT + 1) @(negedge clk);
            chk($sformatf("table %0d (R3/R4/R5/R6/R10)", i), data_out, VECS[i].exp);
        end
        pblk = 1'b0; cfg_pblk_pol = 1'b1; clp_win = 1'b0;
        cfg_blank_lvl = 1'b0; cfg_gray = 1'b0; pix_code = 12'h000;
        repeat (LAT + 1) @(negedge clk);

        // R2: latency of a single marker in both output modes
        for (int m = 0; m < 2; m++) begin
            cfg_transparent = (m == 1);
            pix_code = 12'hABC;
            for (int e = 1; e <= LAT + 2; e++) begin
                @(negedge clk);
                pix_code = 12'h000;
                if (e == LAT - m)
                    chk("R2 marker arrival", data_out, 12'hABC);
                else if (e == LAT - m - 1 || e == LAT - m + 1)
                    chk("R2 marker absent", data_out, 12'h000);
            end
        end
        cfg_transparent = 1'b0;

        // R11: one blanked pixel inside a run stays with its own code
        for (int t = 0; t < LAT + 6; t++) begin
            if (t >= LAT && t - LAT < 6)
                chk($sformatf("R11 pixel %0d", t - LAT), data_out,
                    (t - LAT == 2) ? 12'h000 : 12'h100 + 12'(t - LAT));
            pix_code = (t < 6) ? 12'h100 + 12'(t) : 12'h000;
            pblk = (t == 2);
            @(negedge clk);
        end
        pblk = 1'b0;

        // R7: inactive data clock holds the register
        pix_code = 12'h111;
        repeat (LAT + 1) @(negedge clk);
        chk("R7 preload", data_out, 12'h111);
        dclk = 1'b0; pix_code = 12'h222;
        repeat (LAT + 2) @(negedge clk);
        chk("R7 hold", data_out, 12'h111);
        // R8: transparent path ignores the data clock
        cfg_transparent = 1'b1; #1;
        chk("R8 transparent", data_out, 12'h222);
        cfg_transparent = 1'b0;
        // R10: active-low data clock turns the low level active
        cfg_dclk_pol = 1'b0;
        @(negedge clk);
        chk("R10 data clock low active", data_out, 12'h222);
        pix_code = 12'h333; dclk = 1'b1;
        repeat (LAT + 2) @(negedge clk);
        chk("R10 data clock high inactive", data_out, 12'h222);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule